// File: doc/BRIEF.md
# Display Power-Up Sequencer

This block brings a display controller from reset to a lit screen through a register access engine, and later turns the display on or off when asked. A start pulse first has the engine read the controller's device code. Only the expected code lets the sequence go on. Any other code ends the run at once, raises an error flag and issues no write.

After a good code, the block walks a built-in step table. Each step is either a register write (an index and a 16-bit value) or a wait of a given number of milliseconds. The power-control register is raised through six staged values, with a wait after each one so the supply can settle. Next come the window and partial-screen limits, and the run ends with the display-on pair. Waits are counted in system-clock cycles from a ticks-per-millisecond parameter. The block holds one command at a time toward the engine and moves to the next step only after the engine's done pulse.

Separate on and off requests run short sub-sequences from the same table. Start, on and off are accepted only while the block is idle.

Top module: `disp_pwr_seq`

## Requirements
- R1: After reset, busy, command-valid and the ID error flag are all low.
- R2: A start pulse raises busy. The first command issued is a read (`cmd_read_o`=1) of register index 0x00, and no write precedes it.
- R3: If the read returns a code other than EXPECT_ID (default 0x0154), no write follows, `id_err_o` goes high and busy falls. The flag clears on the next accepted request.
- R4: With a matching code, exactly 16 writes follow, as {index,value}: {07,0000}, {03,1030}, {11,001B}, {11,011B}, {11,031B}, {11,071B}, {11,0F1B}, {11,0F3B}, {36,00EF}, {37,0000}, {38,013F}, {39,0000}, {34,013F}, {35,0000}, {07,0012}, {07,0013}.
- R5: After each of the first five power-control writes, at least 11·TICKS_PER_MS cycles pass before the next command. After the 0x0F3B write, at least 31·TICKS_PER_MS cycles pass.
- R6: A command stays valid, with its index and data unchanged, until the engine's done pulse. No new command starts before that pulse.
- R7: Busy stays high from the accepted request until the last step of its sequence completes, then falls.
- R8: An on request while idle writes 0x0012 and then 0x0013 to index 0x07, with at least ON_WAIT_MS·TICKS_PER_MS cycles between them.
- R9: An off request while idle writes 0x0012 and then 0x0000 to index 0x07, with the same minimum wait between them.
- R10: Start, on and off requests made while busy have no effect: no extra command, and no restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin ID check and full init |
| on_req_i | input | 1 | Request display-on sub-sequence |
| off_req_i | input | 1 | Request display-off sub-sequence |
| busy_o | output | 1 | A sequence is in progress |
| id_err_o | output | 1 | Last ID read returned an unexpected code |
| cmd_valid_o | output | 1 | Command held toward the access engine |
| cmd_read_o | output | 1 | 1 = read command, 0 = write |
| cmd_index_o | output | 8 | Register index of the command |
| cmd_wdata_o | output | 16 | Write value |
| eng_done_i | input | 1 | One-cycle completion pulse from the engine |
| eng_rdata_i | input | 16 | Read data from the engine |

## Verification
The bench returns a code that is one off from the expected value. A design that ignores the ID gate would then show writes, and one that forgets to drop busy would hang. It measures every gap between the staged power writes and the next command. A timer that is short by a cycle or reloads wrongly would show up as a gap below the millisecond floor. It sends start, on and off in the middle of init. A design that accepts them would log more than sixteen writes or restart the ID read. The on and off runs check the last value of the pair, so a swapped table branch is caught.

// File: rtl/disp_seq_pkg.sv
package disp_seq_pkg;

  typedef enum logic [1:0] {E_WR = 2'd0, E_WAIT = 2'd1, E_END = 2'd2} ent_kind_t;

  typedef struct packed {
    ent_kind_t   kind;
    logic [7:0]  idx;
    logic [15:0] val;
  } seq_ent_t;

  localparam logic [7:0] REG_ID       = 8'h00;
  localparam logic [7:0] REG_ENTRY    = 8'h03;
  localparam logic [7:0] REG_DISP     = 8'h07;
  localparam logic [7:0] REG_PWR      = 8'h11;
  localparam logic [7:0] REG_PART_END = 8'h34;
  localparam logic [7:0] REG_PART_BEG = 8'h35;
  localparam logic [7:0] REG_HWIN_END = 8'h36;
  localparam logic [7:0] REG_HWIN_BEG = 8'h37;
  localparam logic [7:0] REG_VWIN_END = 8'h38;
  localparam logic [7:0] REG_VWIN_BEG = 8'h39;

  localparam int SEQ_LEN   = 28;
  localparam int ON_BASE   = 20;
  localparam int OFF_BASE  = 24;
  localparam int RAMP_MS   = 11;
  localparam int SETTLE_MS = 31;

  function automatic seq_ent_t mk_wr(input logic [7:0] i, input logic [15:0] v);
    mk_wr = '{kind: E_WR, idx: i, val: v};
  endfunction

  function automatic seq_ent_t mk_wait(input logic [15:0] ms);
    mk_wait = '{kind: E_WAIT, idx: 8'h00, val: ms};
  endfunction

  // Staged power value: steps 0..4 fill bits 8.. from the bottom, step 5 adds bit 5.
  function automatic logic [15:0] ramp_val(input int step);
    logic [15:0] v;
    if (step >= 5) v = 16'h0F3B;
    else           v = 16'h001B | (16'(((1 << step) - 1)) << 8);
    return v;
  endfunction

  function automatic longint wait_ticks(input logic [15:0] ms, input int tpm);
    return longint'(ms) * longint'(tpm);
  endfunction

  function automatic seq_ent_t seq_entry(input int n, input logic [15:0] on_ms);
    seq_ent_t e;
    case (n)
      0:  e = mk_wr(REG_DISP, 16'h0000);
      1:  e = mk_wr(REG_ENTRY, 16'h1030);
      2, 4, 6, 8, 10, 12: e = mk_wr(REG_PWR, ramp_val((n - 2) / 2));
      3, 5, 7, 9, 11: e = mk_wait(16'(RAMP_MS));
      13: e = mk_wait(16'(SETTLE_MS));
      14: e = mk_wr(REG_HWIN_END, 16'd239);
      15: e = mk_wr(REG_HWIN_BEG, 16'd0);
      16: e = mk_wr(REG_VWIN_END, 16'd319);
      17: e = mk_wr(REG_VWIN_BEG, 16'd0);
      18: e = mk_wr(REG_PART_END, 16'd319);
      19: e = mk_wr(REG_PART_BEG, 16'd0);
      20: e = mk_wr(REG_DISP, 16'h0012);
      21: e = mk_wait(on_ms);
      22: e = mk_wr(REG_DISP, 16'h0013);
      24: e = mk_wr(REG_DISP, 16'h0012);
      25: e = mk_wait(on_ms);
      26: e = mk_wr(REG_DISP, 16'h0000);
      default: e = '{kind: E_END, idx: 8'h00, val: 16'h0000};
    endcase
    return e;
  endfunction

endpackage

// File: rtl/disp_seq_rom.sv
module disp_seq_rom
  import disp_seq_pkg::*;
#(
  parameter int IDX_W      = 5,
  parameter int ON_WAIT_MS = 20
) (
  input  logic [IDX_W-1:0] addr_i,
  output seq_ent_t         ent_o
);
  always_comb ent_o = seq_entry(int'(addr_i), 16'(ON_WAIT_MS));
endmodule

// File: rtl/disp_seq_timer.sv
module disp_seq_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] ticks_i,
  output logic             run_o,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load_i)         cnt_q <= ticks_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign run_o    = (cnt_q != '0);
  assign expire_o = (cnt_q == CNT_W'(1));
endmodule

// File: rtl/disp_pwr_seq.sv
module disp_pwr_seq
  import disp_seq_pkg::*;
#(
  parameter int          TICKS_PER_MS = 100000,
  parameter int          ON_WAIT_MS   = 20,
  parameter logic [15:0] EXPECT_ID    = 16'h0154
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic        on_req_i,
  input  logic        off_req_i,
  output logic        busy_o,
  output logic        id_err_o,
  output logic        cmd_valid_o,
  output logic        cmd_read_o,
  output logic [7:0]  cmd_index_o,
  output logic [15:0] cmd_wdata_o,
  input  logic        eng_done_i,
  input  logic [15:0] eng_rdata_i
);
  localparam int MAX_MS = (ON_WAIT_MS > SETTLE_MS) ? ON_WAIT_MS : SETTLE_MS;
  localparam int CNT_W  = $clog2(MAX_MS * TICKS_PER_MS + 1);
  localparam int IDX_W  = $clog2(SEQ_LEN);

  typedef enum logic [2:0] {S_IDLE, S_ID, S_STEP, S_CMD, S_WAIT} state_t;

  state_t           state;
  logic [IDX_W-1:0] ptr;
  logic             busy_q, err_q, vld_q, rd_q;
  logic [7:0]       idx_q;
  logic [15:0]      dat_q;
  seq_ent_t         cur;
  logic             tmr_load, tmr_run, tmr_expire;
  logic [CNT_W-1:0] tmr_ticks;

  // Named events for the checker
  logic id_match, wait_active, step_adv, req_accept;

  assign id_match    = (eng_rdata_i == EXPECT_ID);
  assign wait_active = (state == S_WAIT);
  assign step_adv    = ((state == S_CMD) && eng_done_i) || ((state == S_WAIT) && tmr_expire);
  assign req_accept  = (state == S_IDLE) && (start_i || on_req_i || off_req_i);
  assign tmr_load    = (state == S_STEP) && (cur.kind == E_WAIT);
  assign tmr_ticks   = CNT_W'(wait_ticks(cur.val, TICKS_PER_MS));

  disp_seq_rom #(.IDX_W(IDX_W), .ON_WAIT_MS(ON_WAIT_MS)) u_rom (
    .addr_i (ptr),
    .ent_o  (cur)
  );

  disp_seq_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (tmr_load),
    .ticks_i  (tmr_ticks),
    .run_o    (tmr_run),
    .expire_o (tmr_expire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      ptr    <= '0;
      busy_q <= 1'b0;
      err_q  <= 1'b0;
      vld_q  <= 1'b0;
      rd_q   <= 1'b0;
      idx_q  <= '0;
      dat_q  <= '0;
    end else begin
      case (state)
        S_IDLE: begin
          if (start_i) begin
            state  <= S_ID;
            busy_q <= 1'b1;
            err_q  <= 1'b0;
            vld_q  <= 1'b1;
            rd_q   <= 1'b1;
            idx_q  <= REG_ID;
            dat_q  <= '0;
          end else if (on_req_i || off_req_i) begin
            state  <= S_STEP;
            busy_q <= 1'b1;
            err_q  <= 1'b0;
            ptr    <= on_req_i ? IDX_W'(ON_BASE) : IDX_W'(OFF_BASE);
          end
        end
        S_ID: begin
          if (eng_done_i) begin
            vld_q <= 1'b0;
            rd_q  <= 1'b0;
            if (id_match) begin
              ptr   <= '0;
              state <= S_STEP;
            end else begin
              err_q  <= 1'b1;
              busy_q <= 1'b0;
              state  <= S_IDLE;
            end
          end
        end
        S_STEP: begin
          case (cur.kind)
            E_WR: begin
              vld_q <= 1'b1;
              idx_q <= cur.idx;
              dat_q <= cur.val;
              state <= S_CMD;
            end
            E_WAIT: state <= S_WAIT;
            default: begin
              busy_q <= 1'b0;
              state  <= S_IDLE;
            end
          endcase
        end
        S_CMD: begin
          if (eng_done_i) begin
            vld_q <= 1'b0;
            ptr   <= ptr + 1'b1;
            state <= S_STEP;
          end
        end
        S_WAIT: begin
          if (tmr_expire) begin
            ptr   <= ptr + 1'b1;
            state <= S_STEP;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy_o      = busy_q;
  assign id_err_o    = err_q;
  assign cmd_valid_o = vld_q;
  assign cmd_read_o  = rd_q;
  assign cmd_index_o = idx_q;
  assign cmd_wdata_o = dat_q;
endmodule

// File: rtl/disp_pwr_seq_chk.sv
module disp_pwr_seq_chk #(
  parameter int TICKS_PER_MS = 100000
) (
  input logic        clk,
  input logic        rst_n,
  input logic        start_i,
  input logic        busy_o,
  input logic        id_err_o,
  input logic        cmd_valid_o,
  input logic        cmd_read_o,
  input logic [7:0]  cmd_index_o,
  input logic [15:0] cmd_wdata_o,
  input logic        eng_done_i,
  input logic        wait_active
);
  int unsigned wait_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           wait_len <= 0;
    else if (wait_active) wait_len <= wait_len + 1;
    else                  wait_len <= 0;
  end

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !cmd_valid_o);

  assert_read_id_reg_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_o && cmd_read_o) |-> (cmd_index_o == 8'h00));

  assert_err_no_cmd_R3: assert property (@(posedge clk) disable iff (!rst_n)
    id_err_o |-> !cmd_valid_o);

  assert_wait_floor_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wait_active) |-> (wait_len >= TICKS_PER_MS));

  assert_no_cmd_in_wait_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wait_active |-> !cmd_valid_o);

  assert_hold_cmd_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_o && !eng_done_i) |=> (cmd_valid_o && $stable(cmd_index_o)
                                      && $stable(cmd_wdata_o) && $stable(cmd_read_o)));

  assert_start_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && start_i) |=> busy_o);
endmodule

bind disp_pwr_seq disp_pwr_seq_chk #(.TICKS_PER_MS(TICKS_PER_MS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .busy_o      (busy_o),
  .id_err_o    (id_err_o),
  .cmd_valid_o (cmd_valid_o),
  .cmd_read_o  (cmd_read_o),
  .cmd_index_o (cmd_index_o),
  .cmd_wdata_o (cmd_wdata_o),
  .eng_done_i  (eng_done_i),
  .wait_active (wait_active)
);

// File: tb/tb_disp_pwr_seq.sv
`timescale 1ns/1ps
module tb_disp_pwr_seq;
  localparam int TPM   = 4;
  localparam int ON_MS = 20;

  // Expected init writes {index, value}
  localparam logic [23:0] EXP_INIT [0:15] = '{
    24'h07_0000, 24'h03_1030, 24'h11_001B, 24'h11_011B, 24'h11_031B, 24'h11_071B,
    24'h11_0F1B, 24'h11_0F3B, 24'h36_00EF, 24'h37_0000, 24'h38_013F, 24'h39_0000,
    24'h34_013F, 24'h35_0000, 24'h07_0012, 24'h07_0013 };

  logic clk = 1'b0, rst_n = 1'b0;
  logic start_i = 0, on_req_i = 0, off_req_i = 0;
  logic busy_o, id_err_o, cmd_valid_o, cmd_read_o;
  logic [7:0] cmd_index_o;
  logic [15:0] cmd_wdata_o;
  logic eng_done_i = 0;
  logic [15:0] id_code = 16'h0154;

  always #2.5 clk = ~clk;

  disp_pwr_seq #(.TICKS_PER_MS(TPM), .ON_WAIT_MS(ON_MS)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .on_req_i(on_req_i),
    .off_req_i(off_req_i), .busy_o(busy_o), .id_err_o(id_err_o),
    .cmd_valid_o(cmd_valid_o), .cmd_read_o(cmd_read_o), .cmd_index_o(cmd_index_o),
    .cmd_wdata_o(cmd_wdata_o), .eng_done_i(eng_done_i), .eng_rdata_i(id_code));

  int checks = 0, fails = 0, cyc = 0, viol = 0;
  logic finished = 0;

  // Engine model with command log
  int          lg_n = 0;
  logic        lg_rd  [0:63];
  logic [23:0] lg_cmd [0:63];
  int          lg_acc [0:63];
  int          lg_done[0:63];
  logic        e_busy = 0, e_gap = 0;
  int          e_cnt = 0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    eng_done_i <= 1'b0;
    if (e_gap) e_gap <= 1'b0;
    else if (!e_busy && cmd_valid_o) begin
      if (lg_n < 64) begin
        lg_rd[lg_n]  <= cmd_read_o;
        lg_cmd[lg_n] <= {cmd_index_o, cmd_wdata_o};
        lg_acc[lg_n] <= cyc;
      end
      e_busy <= 1'b1;
      e_cnt  <= 2;
    end else if (e_busy) begin
      if (!cmd_valid_o) viol <= viol + 1;
      if (e_cnt == 0) begin
        eng_done_i <= 1'b1;
        e_busy <= 1'b0;
        e_gap  <= 1'b1;
        if (lg_n < 64) lg_done[lg_n] <= cyc;
        lg_n <= lg_n + 1;
      end else e_cnt <= e_cnt - 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic pulse_start(); @(negedge clk) start_i = 1; @(negedge clk) start_i = 0; endtask
  task automatic pulse_on();    @(negedge clk) on_req_i = 1; @(negedge clk) on_req_i = 0; endtask
  task automatic pulse_off();   @(negedge clk) off_req_i = 1; @(negedge clk) off_req_i = 0; endtask
  task automatic wait_idle();
    @(negedge clk);
    while (busy_o) @(negedge clk);
    repeat (8) @(negedge clk);
  endtask
  task automatic clear_log(); @(negedge clk) lg_n = 0; endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=0x%0h expected=0x%0h", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!busy_o, "R1 busy", busy_o, 0);
    chk(!cmd_valid_o, "R1 valid", cmd_valid_o, 0);
    chk(!id_err_o, "R1 id_err", id_err_o, 0);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R2/R3 wrong code
    id_code = 16'h0155;
    pulse_start();
    chk(busy_o, "R2 busy after start", busy_o, 1);
    wait_idle();
    chk(lg_n == 1, "R3 only the read", lg_n, 1);
    chk(lg_rd[0] == 1'b1 && lg_cmd[0][23:16] == 8'h00, "R2 read idx 00", lg_cmd[0][23:16], 0);
    chk(id_err_o, "R3 id_err set", id_err_o, 1);
    chk(!busy_o, "R3 busy low", busy_o, 0);

    // R4..R7, R10 good code with requests during busy
    id_code = 16'h0154;
    clear_log();
    pulse_start();
    repeat (40) @(negedge clk);
    chk(busy_o, "R7 busy mid-sequence", busy_o, 1);
    pulse_on(); pulse_off(); pulse_start();
    wait_idle();
    chk(!id_err_o, "R3 id_err cleared", id_err_o, 0);
    chk(lg_n == 17, "R10 command count", lg_n, 17);
    chk(lg_rd[0] == 1'b1, "R2 read first", lg_rd[0], 1);
    for (int i = 0; i < 16; i++) begin
      chk(lg_rd[i+1] == 1'b0 && lg_cmd[i+1] == EXP_INIT[i], "R4 init write",
          lg_cmd[i+1], EXP_INIT[i]);
    end
    for (int i = 3; i <= 7; i++) begin
      chk(lg_acc[i+1] - lg_done[i] >= 11*TPM, "R5 ramp wait",
          lg_acc[i+1] - lg_done[i], 11*TPM);
    end
    chk(lg_acc[9] - lg_done[8] >= 31*TPM, "R5 settle wait", lg_acc[9] - lg_done[8], 31*TPM);
    chk(lg_acc[9] - lg_done[8] < 31*TPM + 10, "R5 settle bounded", lg_acc[9] - lg_done[8], 31*TPM);
    chk(viol == 0, "R6 held until done", viol, 0);
    chk(!busy_o, "R7 busy falls", busy_o, 0);

    // R8 on request
    clear_log();
    pulse_on();
    chk(busy_o, "R7 busy on request", busy_o, 1);
    wait_idle();
    chk(lg_n == 2 && lg_cmd[0] == 24'h07_0012 && lg_cmd[1] == 24'h07_0013,
        "R8 on pair", lg_cmd[1], 24'h07_0013);
    chk(lg_acc[1] - lg_done[0] >= ON_MS*TPM, "R8 on wait", lg_acc[1] - lg_done[0], ON_MS*TPM);

    // R9 off request
    clear_log();
    pulse_off();
    wait_idle();
    chk(lg_n == 2 && lg_cmd[0] == 24'h07_0012 && lg_cmd[1] == 24'h07_0000,
        "R9 off pair", lg_cmd[1], 24'h07_0000);
    chk(lg_acc[1] - lg_done[0] >= ON_MS*TPM, "R9 off wait", lg_acc[1] - lg_done[0], ON_MS*TPM);

    // R10 off request during an on sequence is ignored
    clear_log();
    pulse_on();
    repeat (10) @(negedge clk);
    pulse_off();
    wait_idle();
    chk(lg_n == 2 && lg_cmd[1] == 24'h07_0013, "R10 off ignored", lg_cmd[1], 24'h07_0013);
    chk(viol == 0, "R6 final", viol, 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule